// File: doc/BRIEF.md
# Multi-Field Packet Header Classifier

This block sorts packet headers against a small rule table that software loads through a write port. Each header arrives as a five-field tuple: source address, destination address, source port, destination port and protocol. Every stored rule is compared against the tuple at the same time. The two address fields and the protocol field are compared bit by bit against a rule value, and a per-bit care mask lets a rule express an exact value, a prefix or any other pattern with wildcard bits. The two port fields are compared against an inclusive lower and upper bound held in the rule. A port range is used as it is and is never broken into prefixes.

The five per-field results form one match vector per field, with one bit per rule. These vectors are ANDed with the per-rule "loaded" bits. A priority stage then reports the lowest-numbered rule that matched, or reports a miss. The datapath accepts a header on every cycle and gives each result exactly three cycles after its header, in input order. The block does not parse raw packets, compile rules or act on the result.

Top module: `pkt_classifier`

## Requirements
- R1: After reset no rule is loaded, so every header classifies as a miss until a rule is written. Writing a rule marks it as loaded.
- R2: For the source address, destination address and protocol fields, a care-mask bit of 1 requires the header bit to equal the rule bit. A care-mask bit of 0 accepts either value. A mask of all ones is an exact match, and a run of leading ones is a prefix match.
- R3: A port field matches when lower bound <= port <= upper bound, with both bounds included. A rule whose lower bound is above its upper bound never matches on that field.
- R4: A rule hits only when all five fields match and the rule is loaded.
- R5: When several rules hit, the reported index is the lowest-numbered one among them.
- R6: When no rule hits, res_hit is 0 and res_idx is 0 while res_valid is 1.
- R7: A header sampled with hdr_valid=1 at a clock edge gives res_valid=1 exactly three edges later. Headers may arrive on back-to-back cycles, and results leave in the same order.
- R8: A rule write sampled at the same edge as a header does not affect that header's result. Headers sampled at later edges see the new rule.
- R9: res_valid is 0 in any cycle that has no header three edges earlier, and res_hit is never 1 while res_valid is 0.
- R10: Rewriting a rule index replaces all of its fields. Nothing of the previous contents remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_wr_en | input | 1 | Write the rule fields below into slot rule_wr_idx |
| rule_wr_idx | input | 4 | Rule slot to write (0 = highest priority) |
| rule_sip_val | input | 32 | Source address pattern |
| rule_sip_care | input | 32 | Source address care mask (1 = compare) |
| rule_dip_val | input | 32 | Destination address pattern |
| rule_dip_care | input | 32 | Destination address care mask |
| rule_proto_val | input | 8 | Protocol pattern |
| rule_proto_care | input | 8 | Protocol care mask |
| rule_sport_lo | input | 16 | Source port lower bound (inclusive) |
| rule_sport_hi | input | 16 | Source port upper bound (inclusive) |
| rule_dport_lo | input | 16 | Destination port lower bound (inclusive) |
| rule_dport_hi | input | 16 | Destination port upper bound (inclusive) |
| hdr_valid | input | 1 | Header tuple present this cycle |
| hdr_sip | input | 32 | Header source address |
| hdr_dip | input | 32 | Header destination address |
| hdr_sport | input | 16 | Header source port |
| hdr_dport | input | 16 | Header destination port |
| hdr_proto | input | 8 | Header protocol |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A rule matched |
| res_idx | output | 4 | Index of the winning rule, 0 on a miss |

## Verification
Directed headers are chosen to probe each comparison on its own. Some differ from a rule in one cared bit or in one ignored bit, which separates care from don't-care handling. Some ports sit exactly on a bound or one step outside it, which exposes off-by-one range errors. Some headers fit two rules at once, which tests the priority order, and one header arrives in the same cycle as a rule rewrite, which pins down when a write takes effect. After that, random rule sets and a stream of back-to-back headers are compared with a bench model. Half of these headers are built to fit a chosen rule and half are random. The random phase checks that field results are combined correctly and that results keep their order under full throughput.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;
  localparam int DEF_ADDR_W  = 32;
  localparam int DEF_PORT_W  = 16;
  localparam int DEF_PROTO_W = 8;
  localparam int DEF_RULES   = 16;

  // Order of the per-field match vectors inside the pipeline.
  typedef enum int {
    FLD_SIP   = 0,
    FLD_DIP   = 1,
    FLD_PROTO = 2,
    FLD_SPORT = 3,
    FLD_DPORT = 4
  } fld_e;

  localparam int NUM_FLD = 5;
endpackage

// File: rtl/tern_match.sv
// Per-rule masked equality: cared bits must agree, uncared bits always pass.
module tern_match #(
  parameter int W  = 32,
  parameter int NR = 16
) (
  input  logic [W-1:0]         key,
  input  logic [NR-1:0][W-1:0] pat,
  input  logic [NR-1:0][W-1:0] care,
  output logic [NR-1:0]        hit
);
  for (genvar r = 0; r < NR; r++) begin : g_rule
    logic [W-1:0] bit_ok;
    assign bit_ok = ~(key ^ pat[r]) | ~care[r];
    assign hit[r] = &bit_ok;
  end
endmodule

// File: rtl/range_match.sv
// Per-rule inclusive bound comparison on a port field.
module range_match #(
  parameter int W  = 16,
  parameter int NR = 16
) (
  input  logic [W-1:0]         key,
  input  logic [NR-1:0][W-1:0] lo,
  input  logic [NR-1:0][W-1:0] hi,
  output logic [NR-1:0]        hit
);
  for (genvar r = 0; r < NR; r++) begin : g_rule
    logic ge_lo;
    logic le_hi;
    assign ge_lo  = (key >= lo[r]);
    assign le_hi  = (key <= hi[r]);
    assign hit[r] = ge_lo & le_hi;
  end
endmodule

// File: rtl/prio_pick.sv
// Lowest set bit wins; index reads zero when nothing is requested.
module prio_pick #(
  parameter int NR = 16,
  parameter int IW = 4
) (
  input  logic [NR-1:0] req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rule_store.sv
// Rule table held in flops so every entry is readable in parallel.
module rule_store #(
  parameter int NR      = 16,
  parameter int IW      = 4,
  parameter int ADDR_W  = 32,
  parameter int PORT_W  = 16,
  parameter int PROTO_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [ADDR_W-1:0]         wr_sip_val,
  input  logic [ADDR_W-1:0]         wr_sip_care,
  input  logic [ADDR_W-1:0]         wr_dip_val,
  input  logic [ADDR_W-1:0]         wr_dip_care,
  input  logic [PROTO_W-1:0]        wr_proto_val,
  input  logic [PROTO_W-1:0]        wr_proto_care,
  input  logic [PORT_W-1:0]         wr_sport_lo,
  input  logic [PORT_W-1:0]         wr_sport_hi,
  input  logic [PORT_W-1:0]         wr_dport_lo,
  input  logic [PORT_W-1:0]         wr_dport_hi,
  output logic [NR-1:0]             on,
  output logic [NR-1:0][ADDR_W-1:0] sip_val,
  output logic [NR-1:0][ADDR_W-1:0] sip_care,
  output logic [NR-1:0][ADDR_W-1:0] dip_val,
  output logic [NR-1:0][ADDR_W-1:0] dip_care,
  output logic [NR-1:0][PROTO_W-1:0] proto_val,
  output logic [NR-1:0][PROTO_W-1:0] proto_care,
  output logic [NR-1:0][PORT_W-1:0] sport_lo,
  output logic [NR-1:0][PORT_W-1:0] sport_hi,
  output logic [NR-1:0][PORT_W-1:0] dport_lo,
  output logic [NR-1:0][PORT_W-1:0] dport_hi
);
  // Only the loaded flags are reset; contents are don't-care until loaded.
  always_ff @(posedge clk) begin
    if (rst) begin
      on <= '0;
    end else if (wr_en) begin
      on[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      sip_val[wr_idx]    <= wr_sip_val;
      sip_care[wr_idx]   <= wr_sip_care;
      dip_val[wr_idx]    <= wr_dip_val;
      dip_care[wr_idx]   <= wr_dip_care;
      proto_val[wr_idx]  <= wr_proto_val;
      proto_care[wr_idx] <= wr_proto_care;
      sport_lo[wr_idx]   <= wr_sport_lo;
      sport_hi[wr_idx]   <= wr_sport_hi;
      dport_lo[wr_idx]   <= wr_dport_lo;
      dport_hi[wr_idx]   <= wr_dport_hi;
    end
  end
endmodule

// File: rtl/pkt_classifier.sv
module pkt_classifier
  import pkt_cls_pkg::*;
#(
  parameter int N_RULES = DEF_RULES,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int PORT_W  = DEF_PORT_W,
  parameter int PROTO_W = DEF_PROTO_W,
  localparam int IDX_W  = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rule_wr_en,
  input  logic [IDX_W-1:0]   rule_wr_idx,
  input  logic [ADDR_W-1:0]  rule_sip_val,
  input  logic [ADDR_W-1:0]  rule_sip_care,
  input  logic [ADDR_W-1:0]  rule_dip_val,
  input  logic [ADDR_W-1:0]  rule_dip_care,
  input  logic [PROTO_W-1:0] rule_proto_val,
  input  logic [PROTO_W-1:0] rule_proto_care,
  input  logic [PORT_W-1:0]  rule_sport_lo,
  input  logic [PORT_W-1:0]  rule_sport_hi,
  input  logic [PORT_W-1:0]  rule_dport_lo,
  input  logic [PORT_W-1:0]  rule_dport_hi,
  input  logic               hdr_valid,
  input  logic [ADDR_W-1:0]  hdr_sip,
  input  logic [ADDR_W-1:0]  hdr_dip,
  input  logic [PORT_W-1:0]  hdr_sport,
  input  logic [PORT_W-1:0]  hdr_dport,
  input  logic [PROTO_W-1:0] hdr_proto,
  output logic               res_valid,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_idx
);
  logic [N_RULES-1:0]              t_on;
  logic [N_RULES-1:0][ADDR_W-1:0]  t_sip_val, t_sip_care, t_dip_val, t_dip_care;
  logic [N_RULES-1:0][PROTO_W-1:0] t_proto_val, t_proto_care;
  logic [N_RULES-1:0][PORT_W-1:0]  t_sport_lo, t_sport_hi, t_dport_lo, t_dport_hi;

  rule_store #(
    .NR(N_RULES), .IW(IDX_W), .ADDR_W(ADDR_W), .PORT_W(PORT_W), .PROTO_W(PROTO_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(rule_wr_en), .wr_idx(rule_wr_idx),
    .wr_sip_val(rule_sip_val), .wr_sip_care(rule_sip_care),
    .wr_dip_val(rule_dip_val), .wr_dip_care(rule_dip_care),
    .wr_proto_val(rule_proto_val), .wr_proto_care(rule_proto_care),
    .wr_sport_lo(rule_sport_lo), .wr_sport_hi(rule_sport_hi),
    .wr_dport_lo(rule_dport_lo), .wr_dport_hi(rule_dport_hi),
    .on(t_on),
    .sip_val(t_sip_val), .sip_care(t_sip_care),
    .dip_val(t_dip_val), .dip_care(t_dip_care),
    .proto_val(t_proto_val), .proto_care(t_proto_care),
    .sport_lo(t_sport_lo), .sport_hi(t_sport_hi),
    .dport_lo(t_dport_lo), .dport_hi(t_dport_hi)
  );

  // Stage 1: field comparisons against the table as it stands when the
  // header is sampled, so a same-cycle write cannot reach this header.
  logic [NUM_FLD-1:0][N_RULES-1:0] fld_hit;

  tern_match #(.W(ADDR_W), .NR(N_RULES)) u_m_sip (
    .key(hdr_sip), .pat(t_sip_val), .care(t_sip_care), .hit(fld_hit[FLD_SIP])
  );
  tern_match #(.W(ADDR_W), .NR(N_RULES)) u_m_dip (
    .key(hdr_dip), .pat(t_dip_val), .care(t_dip_care), .hit(fld_hit[FLD_DIP])
  );
  tern_match #(.W(PROTO_W), .NR(N_RULES)) u_m_proto (
    .key(hdr_proto), .pat(t_proto_val), .care(t_proto_care), .hit(fld_hit[FLD_PROTO])
  );
  range_match #(.W(PORT_W), .NR(N_RULES)) u_m_sport (
    .key(hdr_sport), .lo(t_sport_lo), .hi(t_sport_hi), .hit(fld_hit[FLD_SPORT])
  );
  range_match #(.W(PORT_W), .NR(N_RULES)) u_m_dport (
    .key(hdr_dport), .lo(t_dport_lo), .hi(t_dport_hi), .hit(fld_hit[FLD_DPORT])
  );

  logic                            s1_vld;
  logic [NUM_FLD-1:0][N_RULES-1:0] s1_fld;
  logic [N_RULES-1:0]              s1_on;

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= hdr_valid;
    s1_fld <= fld_hit;
    s1_on  <= t_on;
  end

  // Stage 2: combine field vectors with the loaded flags.
  logic [N_RULES-1:0] all_hit;
  always_comb begin
    all_hit = s1_on;
    for (int f = 0; f < NUM_FLD; f++) all_hit &= s1_fld[f];
  end

  logic               s2_vld;
  logic [N_RULES-1:0] s2_hit;

  always_ff @(posedge clk) begin
    if (rst) s2_vld <= 1'b0;
    else     s2_vld <= s1_vld;
    s2_hit <= all_hit;
  end

  // Stage 3: priority pick and registered result.
  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;

  prio_pick #(.NR(N_RULES), .IW(IDX_W)) u_pick (
    .req(s2_hit), .any(pick_any), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= s2_vld;
      res_hit   <= s2_vld & pick_any;
      res_idx   <= (s2_vld & pick_any) ? pick_idx : '0;
    end
  end
endmodule

// File: rtl/pkt_classifier_chk.sv
module pkt_classifier_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rule_wr_en,
  input logic             hdr_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_idx
);
  logic [1:0] age;
  logic       any_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      age    <= '0;
      any_wr <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (rule_wr_en)  any_wr <= 1'b1;
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst || age != 2'd3)
    res_valid == $past(hdr_valid, 3)); // R7

  AST_HIT_IMPLIES_VALID: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid); // R9

  AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_idx == '0)); // R6

  AST_NO_HIT_BEFORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> any_wr); // R1

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid); // R9
endmodule

bind pkt_classifier pkt_classifier_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .rule_wr_en(rule_wr_en), .hdr_valid(hdr_valid),
  .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
);

// File: tb/pkt_classifier_tb.sv
module pkt_classifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rule_wr_en = 1'b0;
  logic [3:0]  rule_wr_idx = '0;
  logic [31:0] rule_sip_val = '0, rule_sip_care = '0, rule_dip_val = '0, rule_dip_care = '0;
  logic [7:0]  rule_proto_val = '0, rule_proto_care = '0;
  logic [15:0] rule_sport_lo = '0, rule_sport_hi = '0, rule_dport_lo = '0, rule_dport_hi = '0;
  logic        hdr_valid = 1'b0;
  logic [31:0] hdr_sip = '0, hdr_dip = '0;
  logic [15:0] hdr_sport = '0, hdr_dport = '0;
  logic [7:0]  hdr_proto = '0;
  logic        res_valid, res_hit;
  logic [3:0]  res_idx;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pkt_classifier u_dut (
    .clk(clk), .rst(rst),
    .rule_wr_en(rule_wr_en), .rule_wr_idx(rule_wr_idx),
    .rule_sip_val(rule_sip_val), .rule_sip_care(rule_sip_care),
    .rule_dip_val(rule_dip_val), .rule_dip_care(rule_dip_care),
    .rule_proto_val(rule_proto_val), .rule_proto_care(rule_proto_care),
    .rule_sport_lo(rule_sport_lo), .rule_sport_hi(rule_sport_hi),
    .rule_dport_lo(rule_dport_lo), .rule_dport_hi(rule_dport_hi),
    .hdr_valid(hdr_valid), .hdr_sip(hdr_sip), .hdr_dip(hdr_dip),
    .hdr_sport(hdr_sport), .hdr_dport(hdr_dport), .hdr_proto(hdr_proto),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the rule table.
  bit          m_on [NR];
  logic [31:0] m_sv [NR], m_sm [NR], m_dv [NR], m_dm [NR];
  logic [7:0]  m_pv [NR], m_pm [NR];
  logic [15:0] m_slo [NR], m_shi [NR], m_dlo [NR], m_dhi [NR];

  // Staged stimulus for the next cycle.
  bit          st_hv, st_we;
  logic [31:0] st_s, st_d;
  logic [15:0] st_sp, st_dp;
  logic [7:0]  st_pr;
  string       st_tag;
  logic [3:0]  st_wi;
  logic [31:0] st_sv, st_sm, st_dv, st_dm;
  logic [7:0]  st_pv, st_pm;
  logic [15:0] st_slo, st_shi, st_dlo, st_dhi;

  // Expected-result pipe: slot 2 is due at the next sampling point.
  bit         e_v [3];
  bit         e_h [3];
  logic [3:0] e_i [3];
  string      e_t [3];

  function automatic void ref_lookup(input logic [31:0] s, d, input logic [15:0] sp, dp,
                                     input logic [7:0] pr, output bit hit, output logic [3:0] idx);
    hit = 0;
    idx = '0;
    for (int r = NR - 1; r >= 0; r--) begin
      if (m_on[r] && (((s ^ m_sv[r]) & m_sm[r]) == 0) && (((d ^ m_dv[r]) & m_dm[r]) == 0) &&
          (((pr ^ m_pv[r]) & m_pm[r]) == 0) && !(sp < m_slo[r]) && !(sp > m_shi[r]) &&
          !(dp < m_dlo[r]) && !(dp > m_dhi[r])) begin
        hit = 1;
        idx = 4'(r);
      end
    end
  endfunction

  task automatic stage_rule(input int wi, input logic [31:0] sv, sm, dv, dm,
                            input logic [7:0] pv, pm, input logic [15:0] slo, shi, dlo, dhi);
    st_we = 1; st_wi = 4'(wi);
    st_sv = sv; st_sm = sm; st_dv = dv; st_dm = dm; st_pv = pv; st_pm = pm;
    st_slo = slo; st_shi = shi; st_dlo = dlo; st_dhi = dhi;
  endtask

  task automatic stage_hdr(input logic [31:0] s, d, input logic [15:0] sp, dp,
                           input logic [7:0] pr, input string tag);
    st_hv = 1; st_s = s; st_d = d; st_sp = sp; st_dp = dp; st_pr = pr; st_tag = tag;
  endtask

  task automatic tick();
    string tg;
    @(negedge clk);
    // Compare the result due now.
    checks++;
    if (e_v[2]) begin
      tg = e_h[2] ? e_t[2] : {e_t[2], "/R6"};
      if (res_valid !== 1'b1 || res_hit !== e_h[2] || res_idx !== e_i[2]) begin
        errors++;
        $display("FAIL %s: valid/hit/idx got %0b/%0b/%0d exp 1/%0b/%0d",
                 tg, res_valid, res_hit, res_idx, e_h[2], e_i[2]);
      end
    end else if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
      errors++;
      $display("FAIL R9: idle cycle valid/hit got %0b/%0b exp 0/0", res_valid, res_hit);
    end
    for (int k = 2; k > 0; k--) begin
      e_v[k] = e_v[k-1]; e_h[k] = e_h[k-1]; e_i[k] = e_i[k-1]; e_t[k] = e_t[k-1];
    end
    // Drive this cycle's stimulus; the header sees the table before the write.
    hdr_valid = st_hv; hdr_sip = st_s; hdr_dip = st_d;
    hdr_sport = st_sp; hdr_dport = st_dp; hdr_proto = st_pr;
    e_v[0] = st_hv;
    e_t[0] = st_tag;
    ref_lookup(st_s, st_d, st_sp, st_dp, st_pr, e_h[0], e_i[0]);
    rule_wr_en = st_we; rule_wr_idx = st_wi;
    rule_sip_val = st_sv; rule_sip_care = st_sm; rule_dip_val = st_dv; rule_dip_care = st_dm;
    rule_proto_val = st_pv; rule_proto_care = st_pm;
    rule_sport_lo = st_slo; rule_sport_hi = st_shi; rule_dport_lo = st_dlo; rule_dport_hi = st_dhi;
    if (st_we) begin
      m_on[st_wi] = 1;
      m_sv[st_wi] = st_sv; m_sm[st_wi] = st_sm; m_dv[st_wi] = st_dv; m_dm[st_wi] = st_dm;
      m_pv[st_wi] = st_pv; m_pm[st_wi] = st_pm;
      m_slo[st_wi] = st_slo; m_shi[st_wi] = st_shi; m_dlo[st_wi] = st_dlo; m_dhi[st_wi] = st_dhi;
    end
    st_hv = 0;
    st_we = 0;
  endtask

  function automatic logic [31:0] prefix_mask(input int len);
    return (len == 0) ? 32'h0 : ~((32'h1 << (32 - len)) - 32'h1);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NR; r++) m_on[r] = 0;
    for (int k = 0; k < 3; k++) begin e_v[k] = 0; e_h[k] = 0; e_i[k] = '0; e_t[k] = ""; end
    st_hv = 0; st_we = 0; st_tag = "";
    st_s = '0; st_d = '0; st_sp = '0; st_dp = '0; st_pr = '0; st_wi = '0;
    st_sv = '0; st_sm = '0; st_dv = '0; st_dm = '0; st_pv = '0; st_pm = '0;
    st_slo = '0; st_shi = '0; st_dlo = '0; st_dhi = '0;

    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_hit !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs valid/hit got %0b/%0b exp 0/0", res_valid, res_hit);
    end
    rst = 0;

    // R1: empty table, every header misses (including an all-zero tuple).
    stage_hdr(32'h0, 32'h0, 16'h0, 16'h0, 8'h0, "R1"); tick();
    stage_hdr(32'h0A000001, 32'hC0A80177, 16'd1234, 16'd80, 8'd6, "R1"); tick();
    tick(); tick();

    // Rule 3: exact source, /24 destination, exact protocol, any source port, port 80 only.
    stage_rule(3, 32'h0A000001, 32'hFFFFFFFF, 32'hC0A80100, 32'hFFFFFF00, 8'd6, 8'hFF,
               16'h0000, 16'hFFFF, 16'd80, 16'd80);
    tick();
    stage_hdr(32'h0A000001, 32'hC0A80177, 16'd1234, 16'd80, 8'd6, "R2/R4"); tick();
    stage_hdr(32'h0A000001, 32'hC0A801FE, 16'd1234, 16'd80, 8'd6, "R2"); tick();       // uncared bits differ
    stage_hdr(32'h0A000001, 32'hC0A80277, 16'd1234, 16'd80, 8'd6, "R2/R4"); tick();    // cared dst bit differs
    stage_hdr(32'h0A000003, 32'hC0A80177, 16'd1234, 16'd80, 8'd6, "R2/R4"); tick();    // exact src off by one bit
    stage_hdr(32'h0A000001, 32'hC0A80177, 16'd1234, 16'd80, 8'd17, "R2/R4"); tick();   // protocol differs
    stage_hdr(32'h0A000001, 32'hC0A80177, 16'd1234, 16'd81, 8'd6, "R3/R4"); tick();    // just above bound
    stage_hdr(32'h0A000001, 32'hC0A80177, 16'd1234, 16'd79, 8'd6, "R3/R4"); tick();    // just below bound
    stage_hdr(32'h0A000001, 32'hC0A80177, 16'h0000, 16'd80, 8'd6, "R3"); tick();
    stage_hdr(32'h0A000001, 32'hC0A80177, 16'hFFFF, 16'd80, 8'd6, "R3"); tick();

    // Rule 5: everything wildcard except source port 1000..2000.
    stage_rule(5, 32'h0, 32'h0, 32'h0, 32'h0, 8'h0, 8'h0, 16'd1000, 16'd2000, 16'h0, 16'hFFFF);
    tick();
    stage_hdr(32'h01020304, 32'h05060708, 16'd1000, 16'd9, 8'd1, "R3"); tick();
    stage_hdr(32'h01020304, 32'h05060708, 16'd2000, 16'd9, 8'd1, "R3"); tick();
    stage_hdr(32'h01020304, 32'h05060708, 16'd999, 16'd9, 8'd1, "R3"); tick();
    stage_hdr(32'h01020304, 32'h05060708, 16'd2001, 16'd9, 8'd1, "R3"); tick();

    // R5: header fits rules 3 and 5 -> 3; then rule 1 matches all -> 1.
    stage_hdr(32'h0A000001, 32'hC0A80105, 16'd1500, 16'd80, 8'd6, "R5"); tick();
    stage_rule(1, 32'h0, 32'h0, 32'h0, 32'h0, 8'h0, 8'h0, 16'h0, 16'hFFFF, 16'h0, 16'hFFFF);
    tick();
    stage_hdr(32'h0A000001, 32'hC0A80105, 16'd1500, 16'd80, 8'd6, "R5"); tick();
    stage_hdr(32'hDEADBEEF, 32'h12345678, 16'd3000, 16'd7, 8'd50, "R5"); tick();

    // R8/R10: rewrite rule 1 with an empty source range in the same cycle as a header.
    stage_rule(1, 32'h0, 32'h0, 32'h0, 32'h0, 8'h0, 8'h0, 16'd10, 16'd5, 16'h0, 16'hFFFF);
    stage_hdr(32'hDEADBEEF, 32'h12345678, 16'd3000, 16'd7, 8'd50, "R8"); tick();
    stage_hdr(32'hDEADBEEF, 32'h12345678, 16'd3000, 16'd7, 8'd50, "R8/R10"); tick();
    stage_hdr(32'hDEADBEEF, 32'h12345678, 16'd7, 16'd7, 8'd50, "R3/R10"); tick();
    tick(); tick(); tick();

    // Random phase: random tables, back-to-back headers, half aimed at a rule.
    for (int round = 0; round < 8; round++) begin
      for (int r = 0; r < NR; r++) begin
        logic [15:0] slo, dlo;
        int sw, dw;
        slo = 16'($urandom); dlo = 16'($urandom);
        sw = $urandom_range(0, 4000); dw = $urandom_range(0, 4000);
        stage_rule(r, $urandom, prefix_mask($urandom_range(0, 32)), $urandom,
                   prefix_mask($urandom_range(0, 32)), 8'($urandom),
                   ($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00,
                   slo, (int'(slo) + sw > 65535) ? 16'hFFFF : 16'(int'(slo) + sw),
                   dlo, (int'(dlo) + dw > 65535) ? 16'hFFFF : 16'(int'(dlo) + dw));
        tick();
      end
      for (int n = 0; n < 300; n++) begin
        if ($urandom_range(0, 9) != 0) begin
          if ($urandom_range(0, 1) != 0) begin
            int r;
            r = $urandom_range(0, NR - 1);
            stage_hdr((m_sv[r] & m_sm[r]) | ($urandom & ~m_sm[r]),
                      (m_dv[r] & m_dm[r]) | ($urandom & ~m_dm[r]),
                      16'(int'(m_slo[r]) + $urandom_range(0, int'(m_shi[r]) - int'(m_slo[r]))),
                      16'(int'(m_dlo[r]) + $urandom_range(0, int'(m_dhi[r]) - int'(m_dlo[r]))),
                      (m_pv[r] & m_pm[r]) | (8'($urandom) & ~m_pm[r]), "R4/R5/R7");
          end else begin
            stage_hdr($urandom, $urandom, 16'($urandom), 16'($urandom), 8'($urandom), "R4/R7");
          end
        end
        tick();
      end
    end
    tick(); tick(); tick(); tick();

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule